// File: doc/BRIEF.md
# Guest Bus Access Trap Mailbox

This block stands between a guest processor bus and a host register port. Guest accesses that must be emulated (I/O or memory) are caught in a mailbox, and the guest is held in a wait state while host software polls a status register, reads the trapped address and moves the data. The host's own data-register accesses complete the trapped cycle. A host read of the data register hands over the write data of a trapped guest write and frees it. A host write to the data register supplies the data for a trapped guest read and frees it.

Guest writes are buffered one deep behind the mailbox, so a stream of guest writes keeps the valid flag up without gaps while the host drains them. Guest reads are held back until every earlier write has drained, which keeps the accesses in order. A control register drives the guest's power-good and high-speed lines. With both lines low the guest is held in reset and its requests are not captured.

Top module: `trap_mailbox`

## Requirements
- R1: After reset, the status, address, data and control registers all read 0, `g_ready` is low and `guest_hold` is high.
- R2: A host write to offset 0x10 loads host bits 17:16 into the control register: bit 0 drives `ctl_pwr` (power-good) and bit 1 drives `ctl_fast` (high-speed). A read of offset 0x10 returns them in bits 1:0. `guest_hold` is high exactly while both bits are 0, and no guest request is captured while it is high.
- R3: A read of offset 0x00 returns the status byte in bits 7:0 and zero in the other bits. Bit 7 is set while an access is held. Bit 6 is set for a 16-bit access and bit 4 for a read. Bits 3:0 carry the 4-bit space code. When nothing is held, the whole register reads 0.
- R4: A read of offset 0x30 returns the 16-bit offset of the held access in bits 15:0, with bits 31:16 zero.
- R5: A guest write is latched, and `g_ready` pulses for one cycle in the cycle after the latch. A read of offset 0x20 returns its data in bits 15:0. A 16-bit write is returned unchanged. For a byte write, the guest's `g_wdata[7:0]` is returned on bits 15:8 when the offset is odd and on bits 7:0 when it is even, and the other byte is zero.
- R6: A host read of offset 0x20 while a write is held frees that write. The valid bit is low one clock later unless another write was buffered or latched in the same cycle.
- R7: While the mailbox holds a write, one more guest write is latched (and acknowledged) into a buffer slot. A third write waits with `g_ready` low until the host frees the mailbox. When the host frees the mailbox, the buffered write moves up without the valid bit dropping.
- R8: A guest read is held with `g_ready` low until the host writes offset 0x20. `g_ready` then pulses one cycle later with `g_rdata` set as follows: for a 16-bit read, host bits 31:16; for a byte read, host bits 23:16 copied onto both bytes.
- R9: A host write of offset 0x20 while a write is held, and a host read of offset 0x20 while a read is held or while nothing is held, leave the mailbox unchanged. A data write followed by a data read therefore empties a mailbox that holds one access of either kind.
- R10: Host write bits 15:0 are ignored for both the control and the data register.
- R11: A guest read is not captured while any write is held or buffered. It is captured only after all earlier writes have been freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| g_req | input | 1 | Guest request, held until `g_ready` is seen |
| g_space | input | 4 | Guest address space code (top of 20-bit address) |
| g_off | input | 16 | Guest address offset |
| g_rd | input | 1 | 1 = guest read, 0 = guest write |
| g_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| g_wdata | input | 16 | Guest write data (a byte uses bits 7:0) |
| g_rdata | output | 16 | Read data returned to the guest |
| g_ready | output | 1 | One-cycle completion pulse to the guest |
| guest_hold | output | 1 | Guest held in reset |
| ctl_fast | output | 1 | High-speed control line |
| ctl_pwr | output | 1 | Power-good control line |
| h_sel | input | 1 | Host register access strobe, one cycle per access |
| h_wr | input | 1 | 1 = host write, 0 = host read |
| h_addr | input | 6 | Host register offset |
| h_wdata | input | 32 | Host write data (values on bits 31:16) |
| h_rdata | output | 32 | Host read data, valid in the strobe cycle |

## Verification
The assertions check several rules on every cycle: the completion pulse lasts one cycle; the buffer slot is never filled while the mailbox is empty and never coexists with a held read; nothing enters the mailbox while the guest is held in reset; and the valid flag drops one clock after the host frees the last access, but survives a promotion. Only the bench's scenarios show the data path: the lane placement of byte writes, the copying of a read byte onto both bytes, that host bits 15:0 are ignored, that guest reads wait behind buffered writes, and the no-effect cases of the flush sequence. The bench's reference model checks the ready pulse, the read data and every host read on each clock.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int SPACE_W = 4;
  localparam int OFF_W   = 16;
  localparam int GDATA_W = 16;
  localparam int HADDR_W = 6;
  localparam int HDATA_W = 32;
  localparam int HALF_W  = GDATA_W / 2;
  localparam int CTL_W   = 2;
  localparam int HLANE_LO = HDATA_W - GDATA_W;

  localparam logic [HADDR_W-1:0] OFS_STATUS = 6'h00;
  localparam logic [HADDR_W-1:0] OFS_CTRL   = 6'h10;
  localparam logic [HADDR_W-1:0] OFS_DATA   = 6'h20;
  localparam logic [HADDR_W-1:0] OFS_ADDR   = 6'h30;

  localparam int ST_VALID = 7;
  localparam int ST_WORD  = 6;
  localparam int ST_READ  = 4;

  typedef struct packed {
    logic               rd;
    logic               word;
    logic [SPACE_W-1:0] space;
    logic [OFF_W-1:0]   off;
    logic [GDATA_W-1:0] data;
  } trap_entry_t;

  // lane placement of guest write data as the host sees it
  function automatic logic [GDATA_W-1:0] place_wdata(input logic word, input logic odd,
                                                      input logic [GDATA_W-1:0] d);
    if (word) return d;
    if (odd)  return {d[HALF_W-1:0], {HALF_W{1'b0}}};
    return {{HALF_W{1'b0}}, d[HALF_W-1:0]};
  endfunction

  // byte reads see the host value on every lane
  function automatic logic [GDATA_W-1:0] spread_rdata(input logic word,
                                                       input logic [GDATA_W-1:0] d);
    if (word) return d;
    return {2{d[HALF_W-1:0]}};
  endfunction

  function automatic logic [7:0] pack_status(input logic v, input trap_entry_t e);
    logic [7:0] s;
    s = '0;
    if (v) begin
      s[ST_VALID]    = 1'b1;
      s[ST_WORD]     = e.word;
      s[ST_READ]     = e.rd;
      s[SPACE_W-1:0] = e.space;
    end
    return s;
  endfunction
endpackage

// File: rtl/trap_slots.sv
module trap_slots
  import trap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pop,
  input  logic        push,
  input  trap_entry_t push_e,
  output logic        cur_v,
  output trap_entry_t cur_e,
  output logic        pnd_v
);
  trap_entry_t pnd_e;
  logic        head_free;

  assign head_free = pop | ~cur_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_v <= 1'b0;
      pnd_v <= 1'b0;
      cur_e <= '0;
      pnd_e <= '0;
    end else if (head_free) begin
      if (pnd_v) begin
        cur_v <= 1'b1;
        cur_e <= pnd_e;
        pnd_v <= push;
        if (push) pnd_e <= push_e;
      end else begin
        cur_v <= push;
        if (push) cur_e <= push_e;
      end
    end else if (push) begin
      pnd_v <= 1'b1;
      pnd_e <= push_e;
    end
  end

  // R7
  behind_head_chk: assert property (@(posedge clk) disable iff (!rst_n) pnd_v |-> cur_v);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) (pnd_v && !pop) |-> !push);
  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !pnd_v && !push) |=> !cur_v);
  // R7
  promote_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && pnd_v) |=> cur_v);
endmodule

// File: rtl/trap_host_port.sv
module trap_host_port
  import trap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_sel,
  input  logic               h_wr,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic [HDATA_W-1:0] h_wdata,
  input  logic               cur_v,
  input  trap_entry_t        cur_e,
  output logic [HDATA_W-1:0] h_rdata,
  output logic               ev_data_rd,
  output logic               ev_data_wr,
  output logic [GDATA_W-1:0] host_val,
  output logic [CTL_W-1:0]   ctl
);
  logic ev_ctl_wr;

  assign ev_data_rd = h_sel & ~h_wr & (h_addr == OFS_DATA);
  assign ev_data_wr = h_sel &  h_wr & (h_addr == OFS_DATA);
  assign ev_ctl_wr  = h_sel &  h_wr & (h_addr == OFS_CTRL);
  assign host_val   = h_wdata[HLANE_LO +: GDATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctl <= '0;
    else if (ev_ctl_wr) ctl <= h_wdata[HLANE_LO +: CTL_W];
  end

  always_comb begin
    h_rdata = '0;
    if (h_sel && !h_wr) begin
      case (h_addr)
        OFS_STATUS: h_rdata[7:0]       = pack_status(cur_v, cur_e);
        OFS_CTRL:   h_rdata[CTL_W-1:0] = ctl;
        OFS_DATA:   if (cur_v) h_rdata[GDATA_W-1:0] = cur_e.data;
        OFS_ADDR:   if (cur_v) h_rdata[OFF_W-1:0]   = cur_e.off;
        default:    h_rdata = '0;
      endcase
    end
  end

  // R2
  ctl_steady_chk: assert property (@(posedge clk) disable iff (!rst_n) !ev_ctl_wr |=> $stable(ctl));
endmodule

// File: rtl/trap_mailbox.sv
module trap_mailbox
  import trap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        g_req,
  input  logic [3:0]  g_space,
  input  logic [15:0] g_off,
  input  logic        g_rd,
  input  logic        g_word,
  input  logic [15:0] g_wdata,
  output logic [15:0] g_rdata,
  output logic        g_ready,
  output logic        guest_hold,
  output logic        ctl_fast,
  output logic        ctl_pwr,
  input  logic        h_sel,
  input  logic        h_wr,
  input  logic [5:0]  h_addr,
  input  logic [31:0] h_wdata,
  output logic [31:0] h_rdata
);
  logic               cur_v, pnd_v;
  trap_entry_t        cur_e, push_e;
  logic               ev_data_rd, ev_data_wr;
  logic [GDATA_W-1:0] host_val;
  logic [CTL_W-1:0]   ctl;
  logic               rel_w, rel_r, pop, live, room_w, acc_w, acc_r, push;

  trap_host_port u_host (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
    .h_wdata(h_wdata), .cur_v(cur_v), .cur_e(cur_e), .h_rdata(h_rdata),
    .ev_data_rd(ev_data_rd), .ev_data_wr(ev_data_wr), .host_val(host_val), .ctl(ctl)
  );

  assign guest_hold = ~|ctl;
  assign ctl_pwr    = ctl[0];
  assign ctl_fast   = ctl[1];

  // host completion events
  assign rel_w = ev_data_rd & cur_v & ~cur_e.rd;
  assign rel_r = ev_data_wr & cur_v &  cur_e.rd;
  assign pop   = rel_w | rel_r;

  // guest capture: a request already acknowledged is masked by g_ready
  assign live   = g_req & ~guest_hold & ~g_ready;
  assign room_w = ~(cur_v & cur_e.rd) & (~pnd_v | pop);
  assign acc_w  = live & ~g_rd & room_w;
  assign acc_r  = live &  g_rd & ~cur_v;
  assign push   = acc_w | acc_r;

  always_comb begin
    push_e       = '0;
    push_e.rd    = g_rd;
    push_e.word  = g_word;
    push_e.space = g_space;
    push_e.off   = g_off;
    push_e.data  = g_rd ? '0 : place_wdata(g_word, g_off[0], g_wdata);
  end

  trap_slots u_slots (
    .clk(clk), .rst_n(rst_n), .pop(pop), .push(push), .push_e(push_e),
    .cur_v(cur_v), .cur_e(cur_e), .pnd_v(pnd_v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_ready <= 1'b0;
      g_rdata <= '0;
    end else begin
      g_ready <= acc_w | rel_r;
      if (rel_r) g_rdata <= spread_rdata(cur_e.word, host_val);
    end
  end

  // R5
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) g_ready |=> !g_ready);
  // R11
  read_alone_chk: assert property (@(posedge clk) disable iff (!rst_n) (cur_v && cur_e.rd) |-> !pnd_v);
  // R2
  hold_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guest_hold && !cur_v) |=> !cur_v);
  // R8
  read_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_v && cur_e.rd && !ev_data_wr) |=> !g_ready);
endmodule

// File: tb/trap_mailbox_tb.sv
module trap_mailbox_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        g_req = 1'b0, g_rd = 1'b0, g_word = 1'b0;
  logic [3:0]  g_space = '0;
  logic [15:0] g_off = '0, g_wdata = '0;
  logic [15:0] g_rdata;
  logic        g_ready, guest_hold, ctl_fast, ctl_pwr;
  logic        h_sel = 1'b0, h_wr = 1'b0;
  logic [5:0]  h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;

  always #5 clk = ~clk;

  trap_mailbox dut_i (
    .clk(clk), .rst_n(rst_n), .g_req(g_req), .g_space(g_space), .g_off(g_off),
    .g_rd(g_rd), .g_word(g_word), .g_wdata(g_wdata), .g_rdata(g_rdata),
    .g_ready(g_ready), .guest_hold(guest_hold), .ctl_fast(ctl_fast), .ctl_pwr(ctl_pwr),
    .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata)
  );

  int nvec = 0, nerr = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {
    bit       rd;
    bit       word;
    bit [3:0] space;
    bit [15:0] off;
    bit [15:0] data;
  } acc_t;

  acc_t      mq[$];
  bit [1:0]  m_ctl;
  bit        m_ready, m_rflag;
  bit [15:0] m_rdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_ctl = 0; m_ready = 0; m_rflag = 0; m_rdata = 0;
    end else begin
      bit hrd, hwr, head_rd, rw, rr, live, aw, ar, nready;
      acc_t a;
      int left;
      hrd = h_sel && !h_wr && h_addr == 6'h20;
      hwr = h_sel &&  h_wr && h_addr == 6'h20;
      head_rd = mq.size() > 0 && mq[0].rd;
      rw = hrd && mq.size() > 0 && !mq[0].rd;
      rr = hwr && head_rd;
      live = g_req && m_ctl != 0 && !m_ready;
      left = mq.size() - ((rw || rr) ? 1 : 0);
      aw = live && !g_rd && !head_rd && left < 2;
      ar = live && g_rd && mq.size() == 0;
      nready = aw || rr;
      if (rr) begin
        if (mq[0].word) m_rdata = h_wdata[31:16];
        else            m_rdata = 16'(h_wdata[23:16]) * 16'd257;
      end
      m_rflag = rr;
      if (rw || rr) void'(mq.pop_front());
      if (aw || ar) begin
        a.rd = g_rd; a.word = g_word; a.space = g_space; a.off = g_off;
        if (g_rd)        a.data = 0;
        else if (g_word) a.data = g_wdata;
        else if (g_off % 2 == 1) a.data = (g_wdata & 16'h00FF) * 16'd256;
        else             a.data = g_wdata & 16'h00FF;
        mq.push_back(a);
      end
      if (h_sel && h_wr && h_addr == 6'h10) m_ctl = h_wdata[17:16];
      m_ready = nready;
    end
  end

  function automatic logic [31:0] exp_host(input logic [5:0] a);
    logic [31:0] v;
    v = 0;
    if (a == 6'h10) v = {30'd0, m_ctl};
    else if (mq.size() > 0) begin
      if (a == 6'h00) v = 32'h80 + (mq[0].word ? 32'h40 : 0) + (mq[0].rd ? 32'h10 : 0) + mq[0].space;
      if (a == 6'h20) v = {16'd0, mq[0].data};
      if (a == 6'h30) v = {16'd0, mq[0].off};
    end
    return v;
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R5/R8 g_ready vs model", {31'd0, g_ready}, {31'd0, m_ready});
      chk("R2 guest_hold vs model", {31'd0, guest_hold}, {31'd0, m_ctl == 0});
      if (m_ready && m_rflag) chk("R8 g_rdata vs model", {16'd0, g_rdata}, {16'd0, m_rdata});
      if (h_sel && !h_wr) chk("R3/R4 host read vs model", h_rdata, exp_host(h_addr));
    end
  end

  // guest drops its request after seeing ready
  always @(negedge clk) begin
    if (g_req && g_ready) begin
      @(posedge clk);
      #1 g_req = 1'b0;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic hrd(input logic [5:0] a, output logic [31:0] v);
    @(posedge clk); #2;
    h_sel = 1; h_wr = 0; h_addr = a;
    @(negedge clk); v = h_rdata;
    @(posedge clk); #2;
    h_sel = 0;
  endtask

  task automatic hwr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    h_sel = 1; h_wr = 1; h_addr = a; h_wdata = d;
    @(posedge clk); #2;
    h_sel = 0; h_wr = 0;
  endtask

  task automatic gstart(input logic rd, input logic word, input logic [3:0] sp,
                        input logic [15:0] off, input logic [15:0] d);
    while (g_req) @(posedge clk);
    @(posedge clk); #2;
    g_rd = rd; g_word = word; g_space = sp; g_off = off; g_wdata = d; g_req = 1;
  endtask

  task automatic gwait(output logic [15:0] rd_val, output bit ok);
    ok = 0; rd_val = 0;
    for (int i = 0; i < 200 && !ok; i++) begin
      @(negedge clk);
      if (g_ready) begin ok = 1; rd_val = g_rdata; end
    end
  endtask

  task automatic finish_run;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog (all requirements) actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [15:0] rv;
    bit ok;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 g_ready after reset", {31'd0, g_ready}, 0);
    chk("R1 guest_hold after reset", {31'd0, guest_hold}, 1);
    hrd(6'h00, v); chk("R1 status after reset", v, 0);
    hrd(6'h30, v); chk("R1 address after reset", v, 0);
    hrd(6'h20, v); chk("R1 data after reset", v, 0);
    hrd(6'h10, v); chk("R1 control after reset", v, 0);

    // R2 request ignored while held in reset
    gstart(0, 1, 4'h1, 16'h0008, 16'h1111);
    repeat (5) @(negedge clk);
    chk("R2 no ready while held", {31'd0, g_ready}, 0);
    hrd(6'h00, v); chk("R2 nothing captured while held", v, 0);
    @(posedge clk); #2 g_req = 0;

    // R2 / R10 release sequence, low host bits ignored
    hwr(6'h10, 32'h0002_FFFF);
    hrd(6'h10, v); chk("R10 control ignores low bits", v, 32'h2);
    @(negedge clk);
    chk("R2 high-speed line", {30'd0, ctl_fast, ctl_pwr}, 32'h2);
    chk("R2 hold released", {31'd0, guest_hold}, 0);
    hwr(6'h10, 32'h0003_0000);
    @(negedge clk);
    chk("R2 power-good line", {30'd0, ctl_fast, ctl_pwr}, 32'h3);

    // R3 R4 R5 R6 word write
    gstart(0, 1, 4'h1, 16'h1234, 16'hBEEF);
    gwait(rv, ok); chk("R5 write acknowledged", {31'd0, ok}, 1);
    hrd(6'h00, v); chk("R3 status word write io", v, 32'hC1);
    hrd(6'h30, v); chk("R4 trapped offset", v, 32'h1234);
    hrd(6'h20, v); chk("R5 word write data", v, 32'hBEEF);
    hrd(6'h00, v); chk("R6 valid cleared after release", v, 0);

    // R7 pipeline with byte lanes
    gstart(0, 0, 4'hA, 16'h0101, 16'h335A);
    gwait(rv, ok); chk("R7 first write acknowledged", {31'd0, ok}, 1);
    gstart(0, 0, 4'hB, 16'h0100, 16'h3377);
    gwait(rv, ok); chk("R7 buffered write acknowledged", {31'd0, ok}, 1);
    gstart(0, 1, 4'h1, 16'h0200, 16'h1357);
    repeat (4) @(negedge clk);
    chk("R7 third write waits", {31'd0, g_ready}, 0);
    hrd(6'h00, v); chk("R3 status byte write mem", v, 32'h8A);
    hrd(6'h20, v); chk("R5 odd byte on high lane", v, 32'h5A00);
    gwait(rv, ok); chk("R7 third write latched after release", {31'd0, ok}, 1);
    hrd(6'h00, v); chk("R7 valid kept on promotion", v, 32'h8B);
    hrd(6'h20, v); chk("R5 even byte on low lane", v, 32'h0077);
    hrd(6'h20, v); chk("R7 third write data", v, 32'h1357);
    hrd(6'h00, v); chk("R6 empty after drain", v, 0);

    // R8 R9 word read
    gstart(1, 1, 4'h1, 16'h0040, 16'h0);
    repeat (3) @(negedge clk);
    chk("R8 read held", {31'd0, g_ready}, 0);
    hrd(6'h00, v); chk("R3 status word read", v, 32'hD1);
    hrd(6'h20, v); chk("R9 data read during read", v, 0);
    hrd(6'h00, v); chk("R9 read not freed by host read", v, 32'hD1);
    hwr(6'h20, 32'hCAFE_1111);
    gwait(rv, ok); chk("R8 read released", {31'd0, ok}, 1);
    chk("R8 R10 word read data", {16'd0, rv}, 32'hCAFE);

    // R8 byte read duplicated
    gstart(1, 0, 4'hC, 16'h0003, 16'h0);
    hrd(6'h00, v); chk("R3 status byte read mem", v, 32'h9C);
    hwr(6'h20, 32'h12AB_0000);
    gwait(rv, ok); chk("R8 byte on both lanes", {16'd0, rv}, 32'hABAB);

    // R11 read waits behind write
    gstart(0, 1, 4'h1, 16'h0010, 16'h2222);
    gwait(rv, ok);
    gstart(1, 1, 4'h1, 16'h0020, 16'h0);
    repeat (3) @(negedge clk);
    hrd(6'h30, v); chk("R11 write stays ahead of read", v, 32'h0010);
    hrd(6'h20, v); chk("R11 write data", v, 32'h2222);
    hrd(6'h00, v); chk("R11 read captured after drain", v, 32'hD1);
    hrd(6'h30, v); chk("R11 read offset", v, 32'h0020);

    // R9 flush sequence
    hwr(6'h20, 32'h0000_0000);
    gwait(rv, ok); chk("R9 flush write frees read", {16'd0, rv}, 0);
    hrd(6'h20, v); chk("R9 flush read on empty", v, 0);
    hrd(6'h00, v); chk("R9 idle after flush", v, 0);
    gstart(0, 1, 4'h1, 16'h0030, 16'h4444);
    gwait(rv, ok);
    hwr(6'h20, 32'hFFFF_0000);
    hrd(6'h00, v); chk("R9 host write keeps held write", v, 32'hC1);
    hrd(6'h20, v); chk("R9 held write data intact", v, 32'h4444);
    hrd(6'h00, v); chk("R9 idle", v, 0);

    // R10 R2 clear control with low bits set
    hwr(6'h10, 32'h0000_0003);
    hrd(6'h10, v); chk("R10 low bits ignored on clear", v, 0);
    @(negedge clk);
    chk("R2 guest held again", {31'd0, guest_hold}, 1);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule